// File: doc/BRIEF.md
# Idle-Bus Instruction Byte Prefetcher

This block keeps a small circular queue of instruction bytes filled ahead of the execution side. It starts a memory read whenever the execution side is not using the bus and the queue has room. Fetching therefore overlaps with decode and execute, so the next instruction is usually already in the queue when the execution side asks for it. The execution side takes one byte per cycle from the head of the queue through a pop input and a byte/valid pair.

A taken branch, or any other change of flow, is signalled through a redirect strobe that carries the new fetch address. The strobe empties the queue at once, and fetching starts again from the new address. A memory read that is already waiting when the redirect arrives still runs to completion on the bus, but its byte is thrown away. Memory reads use a simple held-request handshake. Request and address stay asserted until the memory raises ready, and the data is captured in the cycle that ready is high.

Top module: `ibp_prefetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req_o` and `byte_valid_o` are low, and the first read after reset is for address `RESET_ADDR` (default 0).
- R2: A new read request (`mem_req_o` rising, or staying high right after an accepted read) starts only if `bus_busy_i` was low in the previous cycle. A request that is already waiting is not withdrawn when `bus_busy_i` rises.
- R3: Once raised, `mem_req_o` stays high with `mem_addr_o` unchanged until a cycle in which `mem_ready_i` is high. The read is accepted in that cycle.
- R4: Bytes come out on `byte_o` in the order they were fetched. Each accepted, non-discarded read moves the fetch address up by one, wrapping at 2^AW.
- R5: `byte_valid_o` is low exactly when the queue is empty. A `pop_i` while `byte_valid_o` is low has no effect.
- R6: The queue holds at most `DEPTH` bytes. When it is full and not being popped, no new request starts. After a pop frees a slot, fetching resumes.
- R7: In the cycle after `redirect_i`, `byte_valid_o` is low. All queued bytes are discarded, including a byte accepted in the redirect cycle.
- R8: After a redirect, the next kept byte is read from `redirect_addr_i`, and the following bytes come from consecutive addresses.
- R9: A read that is waiting when `redirect_i` is high (request high, ready low) still completes at its original address, but its data never reaches the queue.
- R10: A pop and an accepted read in the same cycle both take effect, and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_busy_i | input | 1 | Execution side is using the bus this cycle |
| redirect_i | input | 1 | Flush the queue and restart fetching |
| redirect_addr_i | input | AW | New fetch address, sampled with `redirect_i` |
| mem_req_o | output | 1 | Read request to memory |
| mem_addr_o | output | AW | Byte address of the read |
| mem_ready_i | input | 1 | Memory completes the read this cycle |
| mem_data_i | input | 8 | Read data, valid with `mem_ready_i` |
| pop_i | input | 1 | Execution side takes the head byte |
| byte_o | output | 8 | Head byte of the queue |
| byte_valid_o | output | 1 | Queue is not empty |

## Verification
The bench targets redirects at three moments: while a read is still waiting, in the same cycle a read completes, and while the bus is quiet. A design that kept the late byte would deliver a stale instruction in front of the branch target. A design that moved the waiting address would break the memory handshake. It also fills the queue to the top with no pops and then frees one slot. An off-by-one in the room check would either overrun a slot or stall fetching for good. Pops against an empty queue and long runs of bus-busy cycles check that no pointer drifts and that no read is started while the execution side owns the bus.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  typedef logic [7:0] ibyte_t;

  // Wrap-aware pointer step for any depth.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/ibp_queue.sv
module ibp_queue
  import ibp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  ibyte_t        push_data_i,
  input  logic          pop_i,
  output ibyte_t        head_o,
  output logic          valid_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o
);
  ibyte_t        slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  // Power-of-two depth wraps for free, otherwise compare.
  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_ptr_inc = wr_ptr_q + 1'b1;
      assign rd_ptr_inc = rd_ptr_q + 1'b1;
    end else begin : g_mod
      assign wr_ptr_inc = PW'(ptr_step(int'(wr_ptr_q), DEPTH));
      assign rd_ptr_inc = PW'(ptr_step(int'(rd_ptr_q), DEPTH));
    end
  endgenerate

  assign valid_o = (cnt_q != '0);
  assign pop_ok  = pop_i & valid_o;
  assign head_o  = slot_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_next_o = cnt_q;
    if (flush_i) cnt_next_o = '0;
    else if (push_i && !pop_ok) cnt_next_o = cnt_q + 1'b1;
    else if (!push_i && pop_ok) cnt_next_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_next_o;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_i) wr_ptr_q <= wr_ptr_inc;
        if (pop_ok) rd_ptr_q <= rd_ptr_inc;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) slot_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/ibp_fetch.sv
module ibp_fetch #(
  parameter int unsigned    AW         = 16,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_busy_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          room_i,
  input  logic          mem_ready_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          push_o
);
  logic          pend_q, drop_q, accept, issue;
  logic [AW-1:0] fetch_addr_q, fetch_addr_d, req_addr_q;

  assign accept = pend_q & mem_ready_i;
  assign push_o = accept & ~drop_q & ~redirect_i;
  // One read outstanding at most; a new one may chain onto an accepted one.
  assign issue  = (~pend_q | accept) & ~bus_busy_i & ~redirect_i & room_i;

  always_comb begin
    fetch_addr_d = fetch_addr_q;
    if (redirect_i) fetch_addr_d = redirect_addr_i;
    else if (push_o) fetch_addr_d = fetch_addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      drop_q       <= 1'b0;
      fetch_addr_q <= RESET_ADDR;
      req_addr_q   <= RESET_ADDR;
    end else begin
      fetch_addr_q <= fetch_addr_d;
      if (issue) begin
        pend_q     <= 1'b1;
        req_addr_q <= fetch_addr_d;
      end else if (accept) begin
        pend_q <= 1'b0;
      end
      // Waiting read at redirect: let it finish, discard its byte.
      if (redirect_i && pend_q && !mem_ready_i) drop_q <= 1'b1;
      else if (accept) drop_q <= 1'b0;
    end
  end

  assign mem_req_o  = pend_q;
  assign mem_addr_o = req_addr_q;
endmodule

// File: rtl/ibp_prefetch.sv
module ibp_prefetch
  import ibp_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DEPTH      = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_busy_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [7:0]    mem_data_i,
  input  logic          pop_i,
  output logic [7:0]    byte_o,
  output logic          byte_valid_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fill_cnt, fill_cnt_next;
  logic          push, room;

  // Room counts this cycle's push and pop, so the next read always fits.
  assign room = (fill_cnt_next < CW'(DEPTH));

  ibp_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) fetch_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .bus_busy_i      (bus_busy_i),
    .redirect_i      (redirect_i),
    .redirect_addr_i (redirect_addr_i),
    .room_i          (room),
    .mem_ready_i     (mem_ready_i),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .push_o          (push)
  );

  ibp_queue #(.DEPTH(DEPTH)) queue_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (redirect_i),
    .push_i      (push),
    .push_data_i (mem_data_i),
    .pop_i       (pop_i),
    .head_o      (byte_o),
    .valid_o     (byte_valid_o),
    .cnt_o       (fill_cnt),
    .cnt_next_o  (fill_cnt_next)
  );
endmodule

// File: rtl/ibp_prefetch_chk.sv
module ibp_prefetch_chk #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_busy_i,
  input logic          redirect_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          byte_valid_o,
  input logic [CW-1:0] fill_cnt
);
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= CW'(DEPTH));

  // R2
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (!$past(mem_req_o) || $past(mem_ready_i)) |-> !$past(bus_busy_i));

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !byte_valid_o);

  // R5
  empty_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o && !(mem_req_o && mem_ready_i) |=> !byte_valid_o);
endmodule

bind ibp_prefetch ibp_prefetch_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/ibp_prefetch_tb_top.sv
module ibp_prefetch_tb_top;
  localparam int unsigned AW    = 16;
  localparam int unsigned DEPTH = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_busy_i = 1'b1;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_addr_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ready_i = 1'b0;
  logic [7:0]    mem_data_i = '0;
  logic          pop_i = 1'b0;
  logic [7:0]    byte_o;
  logic          byte_valid_o;

  always #5 clk_i = ~clk_i;

  ibp_prefetch #(.AW(AW), .DEPTH(DEPTH)) dut_i (.*);

  int            checks = 0, fails = 0;
  bit            done = 1'b0;
  logic [7:0]    sb[$];
  logic [AW-1:0] exp_addr = '0, pend_addr = '0, prev_addr = '0;
  bit            drop_one = 0;
  int            lat = 0, lat_cnt = 0;
  bit            prev_req = 0, prev_rdy = 0, prev_busy = 1, prev_redir = 0;

  function automatic logic [7:0] mdat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver and monitor for one cycle, evaluated at the falling edge.
  task automatic step(input bit busy, input bit pop, input bit redir, input logic [AW-1:0] tgt);
    logic [7:0] e;
    bit rdy;
    @(negedge clk_i);
    if (mem_req_o && (!prev_req || prev_rdy)) chk(!prev_busy, "R2", prev_busy, 0);
    if (prev_req && !prev_rdy)
      chk(mem_req_o && mem_addr_o == prev_addr, "R3", int'(mem_addr_o), int'(prev_addr));
    if (prev_redir) chk(!byte_valid_o, "R7", byte_valid_o, 0);
    if (pop && !redir && byte_valid_o) begin
      if (sb.size() == 0) chk(0, "R4 unexpected byte", byte_o, 0);
      else begin
        e = sb.pop_front();
        chk(byte_o == e, "R4 R8 R10 byte order", byte_o, e);
      end
    end
    rdy = mem_req_o && (lat_cnt >= lat);
    if (rdy) begin
      if (drop_one || redir) begin
        if (drop_one) chk(mem_addr_o == pend_addr, "R9 dropped read address", int'(mem_addr_o), int'(pend_addr));
        drop_one = 0;
      end else begin
        chk(mem_addr_o == exp_addr, "R4 R8 fetch address", int'(mem_addr_o), int'(exp_addr));
        sb.push_back(mdat(mem_addr_o));
        exp_addr = exp_addr + 1'b1;
      end
      lat_cnt = 0;
    end else if (mem_req_o) lat_cnt++;
    if (redir) begin
      sb.delete();
      exp_addr = tgt;
      if (mem_req_o && !rdy) begin
        drop_one  = 1;
        pend_addr = mem_addr_o;
      end
    end
    bus_busy_i      = busy;
    pop_i           = pop;
    redirect_i      = redir;
    redirect_addr_i = tgt;
    mem_ready_i     = rdy;
    mem_data_i      = rdy ? mdat(mem_addr_o) : 8'h00;
    prev_req = mem_req_o; prev_rdy = rdy; prev_busy = busy;
    prev_addr = mem_addr_o; prev_redir = redir;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(!mem_req_o, "R1 req in reset", mem_req_o, 0);
    chk(!byte_valid_o, "R1 valid in reset", byte_valid_o, 0);
    rst_ni = 1'b1;
    // Bus busy, pops against empty queue
    for (int i = 0; i < 10; i++) begin
      step(1, 1, 0, '0);
      chk(!mem_req_o, "R2 busy blocks fetch", mem_req_o, 0);
      chk(!byte_valid_o, "R5 empty queue", byte_valid_o, 0);
    end
    // Fill to the top with no pops
    for (int i = 0; i < 30; i++) step(0, 0, 0, '0);
    chk(sb.size() == DEPTH, "R6 full count", sb.size(), DEPTH);
    chk(!mem_req_o, "R6 no fetch when full", mem_req_o, 0);
    chk(byte_valid_o, "R6 valid when full", byte_valid_o, 1);
    // First byte is from RESET_ADDR
    chk(byte_o == mdat('0), "R1 R5 first byte", byte_o, mdat('0));
    step(0, 1, 0, '0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0);
    chk(sb.size() == DEPTH, "R6 resume after pop", sb.size(), DEPTH);
    // Streaming with mixed latency, busy and pops
    for (int i = 0; i < 300; i++) begin
      lat = i % 3;
      step((i % 7) < 2, (i % 5) != 0, 0, '0);
    end
    // Redirect while a read is waiting
    lat = 3;
    for (int i = 0; i < 20 && !(mem_req_o && lat_cnt == 1); i++) step(0, 1, 0, '0);
    chk(mem_req_o, "R9 setup waiting read", mem_req_o, 1);
    step(0, 1, 1, 16'h1230);
    lat = 1;
    for (int i = 0; i < 40; i++) step(0, 1, 0, '0);
    chk(!drop_one, "R9 waiting read completed", drop_one, 0);
    // Redirect in the cycle a read completes
    lat = 0;
    for (int i = 0; i < 20 && !mem_req_o; i++) step(0, 1, 0, '0);
    chk(mem_req_o, "R7 setup accept", mem_req_o, 1);
    step(0, 1, 1, 16'h4000);
    for (int i = 0; i < 30; i++) step(0, (i % 2) == 0, 0, '0);
    // Redirect on a quiet bus, target near address wrap
    for (int i = 0; i < 6; i++) step(1, 0, 0, '0);
    chk(!mem_req_o, "R2 quiet bus", mem_req_o, 0);
    step(1, 0, 1, 16'hFFFE);
    for (int i = 0; i < 30; i++) step(0, 1, 0, '0);
    // Drain
    for (int i = 0; i < 6; i++) step(1, 0, 0, '0);
    for (int i = 0; i < DEPTH + 3; i++) step(1, 1, 0, '0);
    chk(sb.size() == 0, "R4 all bytes delivered", sb.size(), 0);
    chk(!byte_valid_o, "R5 drained", byte_valid_o, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule